// File: doc/BRIEF.md
# SPI Register Port with Staged Update

This block is the slave side of a four-wire serial control port that reads and writes a small bank of 8-bit configuration registers. Each transfer opens with a 16-bit instruction word: a direction bit, a two-bit length code and a 13-bit register address. One or more data bytes follow. The length code either fixes the frame at one to three bytes or leaves it open, so that bytes keep flowing until chip select is released. After each byte the working address steps. In most-significant-bit-first mode the address counts down, and in least-significant-bit-first mode it counts up. When a downward walk passes address zero, it wraps to the update-command address.

Written bytes land only in a staging copy of the registers. The copy that drives the rest of the chip (the active copy) changes only when the bus writes a byte with bit 0 set to the update-command address. Staging is then copied into the active set on the following serial-clock rising edge. Read data comes from staging. It is driven on the bidirectional data line together with an output enable, or on a separate output line, as a configuration input selects.

The serial pins are sampled by a faster system clock, and edges are found by comparing each sample with the previous one. The serial inputs are assumed to be synchronous to that clock already.

Top module: `spi_reg_port`

## Requirements
- R1: The instruction word is 16 bits. Bit 15 is the direction (1 = read), bits 14:13 are the length code and bits 12:0 are the start address. With `cfg_lsb_first` = 0 it is sent bit 15 first.
- R2: Incoming bits are taken on serial-clock rising edges. Read data changes only after serial-clock falling edges, so it is stable across each rising edge.
- R3: Length codes 00, 01 and 10 end the frame after 1, 2 and 3 data bytes. Any further bits in that frame are ignored.
- R4: Length code 11 keeps transferring bytes until chip select goes high.
- R5: With `cfg_lsb_first` = 0, the address decrements after each byte and bits move most significant first. With `cfg_lsb_first` = 1, the instruction and data bits are sent bit 0 first and the address increments.
- R6: A decrementing transfer that completes a byte at address 0x000 continues at address 0x232.
- R7: A write changes only the staging copy. The active copy keeps its value until an update is triggered.
- R8: Writing a byte whose bit 0 is 1 to address 0x232 copies all staging registers into the active copy on the next serial-clock rising edge, even with chip select high. A 0 in bit 0 triggers nothing. Reads of 0x232 return 0.
- R9: Registers exist at addresses 0 to NREGS-1. Writes to any other address change no register, and reads from them return 0x00.
- R10: Raising chip select in the middle of a byte discards that byte. The next frame starts with a fresh instruction word.
- R11: With `cfg_sdo_sep` = 0, read bits appear on `spi_sdio_out` and `spi_sdio_oe` is high during the data phase of a read. With `cfg_sdo_sep` = 1, read bits appear on `spi_sdo` and `spi_sdio_oe` stays low.
- R12: After reset, all staging and active registers are 0x00 and `spi_sdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_sdio_in | input | 1 | Serial data into the port |
| cfg_lsb_first | input | 1 | 1 = least significant bit first with incrementing addresses |
| cfg_sdo_sep | input | 1 | 1 = read data goes on the separate output line |
| spi_sdio_out | output | 1 | Read data for the shared data line |
| spi_sdio_oe | output | 1 | Drive enable for the shared data line |
| spi_sdo | output | 1 | Read data on the separate output line (0 when not selected) |
| stage_regs | output | NREGS*8 | Staging registers, register i in bits 8i+7:8i |
| active_regs | output | NREGS*8 | Active registers, same layout |

## Verification
The bench uses the default parameters: eight registers, with both the update-command address and the wrap target at 0x232. With only eight registers, every register can be written one by one. A single ten-byte downward read can then start at the top register, pass through every mapped address, wrap to 0x232 and step onward into unmapped space. Both bit orders and both read-out lines are exercised on this bank. Expected register images are computed in the bench from the bytes it sends.

// File: rtl/spi_reg_pkg.sv
// Shared types for the serial register port.
// Assumes a fixed 16-bit instruction word with a 13-bit address field.
package spi_reg_pkg;
    localparam int HDR_BITS   = 16;
    localparam int HDR_ADDR_W = 13;

    // Frame phase: instruction word, data bytes, or finished (ignoring bits).
    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_DATA = 2'd1,
        PH_IDLE = 2'd2
    } spi_phase_t;

    // Instruction word layout, most significant field first.
    typedef struct packed {
        logic                  rd;
        logic [1:0]            len;
        logic [HDR_ADDR_W-1:0] addr;
    } spi_hdr_t;

    localparam logic [1:0] LEN_STREAM = 2'b11;
endpackage

// File: rtl/spi_bit_shifter.sv
// Collects serial bits into the instruction word and into data bytes.
// A single 16-bit shift register serves both phases; the bit order input
// picks the shift direction. Assumes bit_rise is a one-cycle pulse.
module spi_bit_shifter
    import spi_reg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       bit_rise,
    input  logic       lsb_first,
    input  logic       din,
    input  spi_phase_t phase,
    output logic       hdr_done,
    output spi_hdr_t   hdr_word,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic       cnt_zero
);
    localparam int CNT_W = $clog2(HDR_BITS);

    logic [HDR_BITS-1:0] sh_q;
    logic [HDR_BITS-1:0] sh_nxt;
    logic [CNT_W-1:0]    cnt_q;
    logic                last_bit;
    logic                shifting;

    // Next shift value, end-of-field detection and decoded outputs.
    always_comb begin
        sh_nxt    = lsb_first ? {din, sh_q[HDR_BITS-1:1]} : {sh_q[HDR_BITS-2:0], din};
        last_bit  = (phase == PH_HDR) ? (cnt_q == CNT_W'(HDR_BITS - 1))
                                      : (cnt_q == CNT_W'(7));
        shifting  = bit_rise && !cs_n && (phase != PH_IDLE);
        hdr_done  = shifting && (phase == PH_HDR) && last_bit;
        byte_done = shifting && (phase == PH_DATA) && last_bit;
        hdr_word  = spi_hdr_t'(sh_nxt);
        byte_val  = lsb_first ? sh_nxt[HDR_BITS-1:HDR_BITS-8] : sh_nxt[7:0];
        cnt_zero  = (cnt_q == '0);
    end

    // Shift register and bit counter; chip select high clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (cs_n) begin
            cnt_q <= '0;
        end else if (shifting) begin
            sh_q  <= sh_nxt;
            cnt_q <= last_bit ? '0 : cnt_q + CNT_W'(1);
        end
    end

    AST_DATA_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA) |-> (cnt_q < CNT_W'(8))); // R1
endmodule

// File: rtl/spi_addr_step.sv
// Computes the address for the next byte of a transfer.
// Counting up wraps at the top of the address space; counting down from
// zero jumps to WRAP_ADDR.
module spi_addr_step #(
    parameter int                 ADDR_W    = 13,
    parameter logic [ADDR_W-1:0]  WRAP_ADDR = 13'h232
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ascend_i,
    output logic [ADDR_W-1:0] addr_o
);
    // Up or down step with the downward wrap.
    always_comb begin
        if (ascend_i)
            addr_o = addr_i + ADDR_W'(1);
        else if (addr_i == '0)
            addr_o = WRAP_ADDR;
        else
            addr_o = addr_i - ADDR_W'(1);
    end
endmodule

// File: rtl/spi_stage_bank.sv
// Staging and active register copies plus the update trigger.
// A write of bit 0 = 1 to UPD_ADDR arms a pending flag; the next serial
// clock rise copies staging into active. Assumes wr_en is a one-cycle pulse.
module spi_stage_bank #(
    parameter int                ADDR_W   = 13,
    parameter int                NREGS    = 8,
    parameter logic [ADDR_W-1:0] UPD_ADDR = 13'h232
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [7:0]         rd_data,
    output logic [NREGS*8-1:0] stage_flat,
    output logic [NREGS*8-1:0] active_flat
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NREGS);

    logic [7:0] stage_q  [NREGS];
    logic [7:0] active_q [NREGS];
    logic       upd_pend_q;
    logic       upd_hit;
    logic       copy_now;

    // Detect the update command and the edge that performs the copy.
    always_comb begin
        upd_hit  = wr_en && (wr_addr == UPD_ADDR) && wr_data[0];
        copy_now = sclk_rise && upd_pend_q;
    end

    // Pending-update flag: set by the command, cleared by the copying edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            upd_pend_q <= 1'b0;
        else if (upd_hit)
            upd_pend_q <= 1'b1;
        else if (sclk_rise)
            upd_pend_q <= 1'b0;
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        // Staging register g: loaded by a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[g] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                stage_q[g] <= wr_data;
        end

        // Active register g: follows staging only on an update.
        always_ff @(posedge clk) begin
            if (!rst_n)
                active_q[g] <= '0;
            else if (copy_now)
                active_q[g] <= stage_q[g];
        end

        assign stage_flat[g*8 +: 8]  = stage_q[g];
        assign active_flat[g*8 +: 8] = active_q[g];
    end

    // Read mux over staging; unmapped addresses read as zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREGS; i++)
            if (rd_addr == ADDR_W'(i))
                rd_data = stage_q[i];
    end

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && ($past(wr_addr) >= LIMIT)) |-> $stable(stage_flat)); // R9
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(upd_pend_q) |-> $stable(active_flat)); // R7
    AST_COPY_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sclk_rise && upd_pend_q) |-> (active_flat == $past(stage_flat))); // R8
endmodule

// File: rtl/spi_reg_port.sv
// Serial register port top: edge detection, frame sequencing, address
// stepping and read-out. Assumes the serial pins are already synchronous
// to clk and that each serial clock level lasts at least two clk cycles.
module spi_reg_port
    import spi_reg_pkg::*;
#(
    parameter int                    NREGS     = 8,
    parameter logic [HDR_ADDR_W-1:0] UPD_ADDR  = 13'h232,
    parameter logic [HDR_ADDR_W-1:0] WRAP_ADDR = 13'h232
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_cs_n,
    input  logic               spi_sclk,
    input  logic               spi_sdio_in,
    input  logic               cfg_lsb_first,
    input  logic               cfg_sdo_sep,
    output logic               spi_sdio_out,
    output logic               spi_sdio_oe,
    output logic               spi_sdo,
    output logic [NREGS*8-1:0] stage_regs,
    output logic [NREGS*8-1:0] active_regs
);
    localparam int ADDR_W = HDR_ADDR_W;

    logic              sclk_q;
    logic              rise;
    logic              fall;
    spi_phase_t        phase_q;
    logic              rw_q;
    logic              stream_q;
    logic [1:0]        left_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nxt;
    logic [7:0]        rd_sh_q;
    logic              rd_act_q;
    logic              rd_bit;
    logic              hdr_done;
    spi_hdr_t          hdr_word;
    logic              byte_done;
    logic [7:0]        byte_val;
    logic              cnt_zero;
    logic              wr_en;
    logic [7:0]        rd_data;

    // Serial clock edges seen by the system clock.
    always_comb begin
        rise   = spi_sclk && !sclk_q;
        fall   = !spi_sclk && sclk_q && !spi_cs_n;
        wr_en  = byte_done && !rw_q;
        rd_bit = cfg_lsb_first ? rd_sh_q[0] : rd_sh_q[7];
    end

    spi_bit_shifter i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (spi_cs_n),
        .bit_rise  (rise),
        .lsb_first (cfg_lsb_first),
        .din       (spi_sdio_in),
        .phase     (phase_q),
        .hdr_done  (hdr_done),
        .hdr_word  (hdr_word),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .cnt_zero  (cnt_zero)
    );

    spi_addr_step #(.ADDR_W(ADDR_W), .WRAP_ADDR(WRAP_ADDR)) i_step (
        .addr_i   (addr_q),
        .ascend_i (cfg_lsb_first),
        .addr_o   (addr_nxt)
    );

    spi_stage_bank #(.ADDR_W(ADDR_W), .NREGS(NREGS), .UPD_ADDR(UPD_ADDR)) i_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise   (rise),
        .wr_en       (wr_en),
        .wr_addr     (addr_q),
        .wr_data     (byte_val),
        .rd_addr     (addr_q),
        .rd_data     (rd_data),
        .stage_flat  (stage_regs),
        .active_flat (active_regs)
    );

    // Frame sequencer: instruction decode, byte counting, address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            phase_q  <= PH_HDR;
            rw_q     <= 1'b0;
            stream_q <= 1'b0;
            left_q   <= '0;
            addr_q   <= '0;
        end else begin
            sclk_q <= spi_sclk;
            if (spi_cs_n) begin
                phase_q <= PH_HDR;
            end else if (hdr_done) begin
                rw_q     <= hdr_word.rd;
                stream_q <= (hdr_word.len == LEN_STREAM);
                left_q   <= hdr_word.len;
                addr_q   <= hdr_word.addr;
                phase_q  <= PH_DATA;
            end else if (byte_done) begin
                addr_q <= addr_nxt;
                if (!stream_q) begin
                    if (left_q == 2'd0)
                        phase_q <= PH_IDLE;
                    else
                        left_q <= left_q - 2'd1;
                end
            end
        end
    end

    // Read shifter: load a byte on the first falling edge, shift on the rest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sh_q  <= '0;
            rd_act_q <= 1'b0;
        end else if (spi_cs_n) begin
            rd_act_q <= 1'b0;
        end else if (byte_done && !stream_q && (left_q == 2'd0)) begin
            rd_act_q <= 1'b0;
        end else if (fall && (phase_q == PH_DATA) && rw_q) begin
            if (cnt_zero) begin
                rd_sh_q  <= rd_data;
                rd_act_q <= 1'b1;
            end else begin
                rd_sh_q <= cfg_lsb_first ? {1'b0, rd_sh_q[7:1]} : {rd_sh_q[6:0], 1'b0};
            end
        end
    end

    assign spi_sdio_out = rd_bit;
    assign spi_sdio_oe  = rd_act_q && !cfg_sdo_sep;
    assign spi_sdo      = cfg_sdo_sep ? rd_bit : 1'b0;

    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(byte_done && !cfg_lsb_first && (addr_q == '0)) |-> (addr_q == WRAP_ADDR)); // R6
    AST_OE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spi_cs_n) |-> !spi_sdio_oe); // R11
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fall) |-> $stable(rd_sh_q)); // R2
    AST_LEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(byte_done && !stream_q && (left_q == 2'd0)) |-> (phase_q == PH_IDLE)); // R3
endmodule

// File: tb/test_spi_reg_port.sv
module test_spi_reg_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int NR         = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_sclk = 1'b0;
    logic spi_sdio_in = 1'b0;
    logic lsb = 1'b0;
    logic sep = 1'b0;
    logic spi_sdio_out, spi_sdio_oe, spi_sdo;
    logic [NR*8-1:0] stage_regs, active_regs;

    int n_chk = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    logic [7:0] tx [0:15];
    logic [7:0] rx [0:15];
    logic [7:0] es [NR];
    logic [7:0] ea [NR];
    logic oe_all, oe_any, stable_all;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_port i_spi_reg_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .spi_cs_n      (spi_cs_n),
        .spi_sclk      (spi_sclk),
        .spi_sdio_in   (spi_sdio_in),
        .cfg_lsb_first (lsb),
        .cfg_sdo_sep   (sep),
        .spi_sdio_out  (spi_sdio_out),
        .spi_sdio_oe   (spi_sdio_oe),
        .spi_sdo       (spi_sdo),
        .stage_regs    (stage_regs),
        .active_regs   (active_regs)
    );

    function automatic logic [NR*8-1:0] pack(input logic [7:0] r [NR]);
        logic [NR*8-1:0] v;
        for (int i = 0; i < NR; i++) v[i*8 +: 8] = r[i];
        return v;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic dat, output logic got);
        logic rd_now;
        spi_sdio_in = b;
        repeat (HALF) @(negedge clk);
        got = sep ? spi_sdo : spi_sdio_out;
        if (dat) begin
            oe_all = oe_all & spi_sdio_oe;
            oe_any = oe_any | spi_sdio_oe;
        end
        spi_sclk = 1'b1;
        repeat (2) @(negedge clk);
        rd_now = sep ? spi_sdo : spi_sdio_out;
        if (dat && rd_now !== got) stable_all = 1'b0;
        repeat (HALF - 2) @(negedge clk);
        spi_sclk = 1'b0;
    endtask

    task automatic frame(input logic rw, input logic [1:0] w, input logic [12:0] a,
                         input int nb, input int part);
        logic [15:0] hw;
        logic [7:0]  acc;
        logic        got;
        hw = {rw, w, a};
        oe_all = 1'b1; oe_any = 1'b0; stable_all = 1'b1;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 16; i++) send_bit(lsb ? hw[i] : hw[15-i], 1'b0, got);
        for (int j = 0; j < nb; j++) begin
            acc = '0;
            for (int k = 0; k < 8; k++) begin
                send_bit(lsb ? tx[j][k] : tx[j][7-k], 1'b1, got);
                acc = lsb ? {got, acc[7:1]} : {acc[6:0], got};
            end
            rx[j] = acc;
        end
        for (int k = 0; k < part; k++) send_bit(lsb ? tx[nb][k] : tx[nb][7-k], 1'b0, got);
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic sclk_pulse();
        spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R12 act=hung exp=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NR; i++) begin es[i] = '0; ea[i] = '0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk(stage_regs == '0 && active_regs == '0 && !spi_sdio_oe, "R12 reset",
            {stage_regs[31:0], active_regs[31:0]}, 64'h0);

        // R1 R3 R7: single-byte writes to every register, msb first
        for (int i = 0; i < NR; i++) begin
            tx[0] = 8'(8'h11 * i + 8'h03);
            frame(1'b0, 2'b00, 13'(i), 1, 0);
            es[i] = tx[0];
            chk(stage_regs == pack(es), "R1 single write", stage_regs, pack(es));
        end
        chk(active_regs == pack(ea), "R7 active untouched", active_regs, pack(ea));

        // R8: update command waits for the next serial clock rise
        tx[0] = 8'h01;
        frame(1'b0, 2'b00, 13'h232, 1, 0);
        chk(active_regs == pack(ea), "R8 before rise", active_regs, pack(ea));
        sclk_pulse();
        for (int i = 0; i < NR; i++) ea[i] = es[i];
        chk(active_regs == pack(ea), "R8 after rise", active_regs, pack(ea));

        // R4 R5 R6 R9 R2 R11: downward streaming read through wrap
        for (int j = 0; j < 10; j++) tx[j] = 8'h00;
        frame(1'b1, 2'b11, 13'd7, 10, 0);
        for (int j = 0; j < 10; j++) begin
            logic [7:0] e;
            e = (j < NR) ? es[NR-1-j] : 8'h00;
            chk(rx[j] == e, "R4 R5 R6 stream read", 64'(rx[j]), 64'(e));
        end
        chk(oe_all, "R11 oe during read", 64'(oe_all), 64'h1);
        chk(stable_all, "R2 stable across rise", 64'(stable_all), 64'h1);

        // R6 R9 R7: downward streaming write through wrap, zero update byte
        tx[0] = 8'hA1; tx[1] = 8'hB2; tx[2] = 8'h00; tx[3] = 8'hC4;
        frame(1'b0, 2'b11, 13'd1, 4, 0);
        es[1] = 8'hA1; es[0] = 8'hB2;
        chk(stage_regs == pack(es), "R6 R9 stream write", stage_regs, pack(es));
        sclk_pulse();
        chk(active_regs == pack(ea), "R7 R8 zero bit no update", active_regs, pack(ea));

        // R5: lsb first, incrementing write
        lsb = 1'b1;
        tx[0] = 8'h5A; tx[1] = 8'h3C;
        frame(1'b0, 2'b01, 13'd4, 2, 0);
        es[4] = 8'h5A; es[5] = 8'h3C;
        chk(stage_regs == pack(es), "R5 lsb write", stage_regs, pack(es));

        // R5 R11: lsb first read on separate line, three bytes
        sep = 1'b1;
        frame(1'b1, 2'b10, 13'd5, 3, 0);
        for (int j = 0; j < 3; j++)
            chk(rx[j] == es[5+j], "R5 R11 sep read", 64'(rx[j]), 64'(es[5+j]));
        chk(!oe_any, "R11 oe low when separate", 64'(oe_any), 64'h0);
        chk(stable_all, "R2 stable sep", 64'(stable_all), 64'h1);
        sep = 1'b0;
        lsb = 1'b0;

        // R3: one-byte frame ignores a following byte
        tx[0] = 8'h77; tx[1] = 8'h99;
        frame(1'b0, 2'b00, 13'd2, 2, 0);
        es[2] = 8'h77;
        chk(stage_regs == pack(es), "R3 one byte limit", stage_regs, pack(es));

        // R3: two-byte frame ignores a third byte
        tx[0] = 8'h12; tx[1] = 8'h34; tx[2] = 8'h56;
        frame(1'b0, 2'b01, 13'd7, 3, 0);
        es[7] = 8'h12; es[6] = 8'h34;
        chk(stage_regs == pack(es), "R3 two byte limit", stage_regs, pack(es));

        // R10: abort mid-byte, then a clean frame
        tx[0] = 8'hEE;
        frame(1'b0, 2'b00, 13'd3, 0, 5);
        chk(stage_regs == pack(es), "R10 abort discards", stage_regs, pack(es));
        tx[0] = 8'h42;
        frame(1'b0, 2'b00, 13'd3, 1, 0);
        es[3] = 8'h42;
        chk(stage_regs == pack(es), "R10 fresh frame", stage_regs, pack(es));

        // R9: unmapped write and read
        tx[0] = 8'hFF;
        frame(1'b0, 2'b00, 13'h100, 1, 0);
        chk(stage_regs == pack(es), "R9 unmapped write", stage_regs, pack(es));
        tx[0] = 8'h00;
        frame(1'b1, 2'b00, 13'h100, 1, 0);
        chk(rx[0] == 8'h00, "R9 unmapped read", 64'(rx[0]), 64'h0);
        frame(1'b1, 2'b00, 13'h232, 1, 0);
        chk(rx[0] == 8'h00, "R8 update reads zero", 64'(rx[0]), 64'h0);

        // R8 R6: update reached by wrapping inside a stream
        tx[0] = 8'h6D; tx[1] = 8'h01;
        frame(1'b0, 2'b11, 13'd0, 2, 0);
        es[0] = 8'h6D;
        chk(active_regs == pack(ea), "R8 stream update pending", active_regs, pack(ea));
        sclk_pulse();
        for (int i = 0; i < NR; i++) ea[i] = es[i];
        chk(active_regs == pack(ea), "R8 stream update copied", active_regs, pack(ea));

        finish_run();
    end
endmodule